// File: doc/BRIEF.md
# Priority-Sorting Interrupt Controller

This block collects a vector of level-sensitive interrupt sources and presents them to a processor on two request lines: a normal request and a fast request. Each source has its own configuration word that holds a 7-bit priority, a blocking bit and a routing bit that selects which request line the source competes for. When a request line is idle and an eligible source is pending, the controller starts a sort of fixed length. At the end of the sort it raises the request line and publishes the winning source number and its priority in two readable status words per line.

The sort is watched while it runs. If the source that started it drops during the window, or if a write to a source configuration word during the window changes the result, the status words carry an all-ones flag field above the number and priority. Software can set a common priority level register to let only more urgent sources through, which allows nested handling. Gated sources stay pending and are delivered once the level admits them. Each line is released by writing its bit in the control word, and the next sort then starts on its own.

Top module: `prio_irq_sorter`

## Requirements
- R1: After reset both request lines are low, the level register reads 0x000000FF, the four status words read 0, and every source configuration word reads 0x00000080 (blocked, normal line, priority 0).
- R2: Source i has a configuration word at word address 0x80+i with priority in bits [6:0], a blocking bit in bit 7 (1 blocks the source) and a route bit in bit 8 (1 sends it to the fast line). The word reads back as written in bits [8:0], with zeros above. Writes to addresses for source numbers at or above the number of sources are ignored, and reads there return 0.
- R3: When a line is idle and an eligible source is pending at a rising clock edge, the line goes high exactly 10 rising edges later.
- R4: The winner is the pending eligible source with the numerically lowest priority value. On equal priority the lower source number wins. The number status word holds the winner number in bits [6:0], and the priority status word holds its priority in bits [6:0]. Normal line: number at 0x04, priority at 0x05. Fast line: number at 0x06, priority at 0x07.
- R5: A line considers only unblocked sources routed to it, and the two lines sort independently of each other.
- R6: A line stays high until a write to the control word at 0x00 sets its release bit: bit 0 for the normal line, bit 1 for the fast line. Both may be set in one write. The line is low from the next edge on.
- R7: A source that becomes pending while a sort is running does not take part in that sort. Once the line is released, a new sort starts one edge later and includes it.
- R8: The level register is at 0x01 and holds 8 bits. A value from 0x00 to 0x7F enables gating on both lines: only sources with a priority value below the level may start or win a sort. A value of 0x80 or higher disables gating.
- R9: A source held back by the level stays pending and is delivered once the level is raised above its priority value.
- R10: If the source that started a sort is low at any edge of the sort window, the result is flagged. Bits [31:7] of both status words of that line then read all ones. Otherwise they read all zeros.
- R11: If a source configuration write lands during the sort window and the winner among the sources pending at the start of the sort differs in number or priority at the end of the window, the result is flagged. A write that leaves that winner unchanged does not flag it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_SRC | Level-sensitive interrupt sources, active high |
| bus_we_i | input | 1 | Register write strobe, one write per cycle |
| bus_addr_i | input | ADDR_W | Register word address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data, combinational from the address |
| norm_req_o | output | 1 | Normal interrupt request, level |
| fast_req_o | output | 1 | Fast interrupt request, level |

## Verification
The bench targets the exact edge on which a request rises, and tie-breaking between equal priorities. A design that is off by one edge, or that picks the higher source number, fails at once. It also raises a more urgent source in the middle of a sort, where a design that keeps re-sorting would report the late source instead of finishing the running sort. The two spurious cases are checked together with their harmless neighbour, a configuration write that leaves the winner unchanged, so that a design flagging every mid-window write is caught. Level gating is checked on both lines and then relaxed, to show that a gated source was kept pending rather than dropped.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

   localparam int STAT_W = 7;
   localparam int NUM_CH = 2;

   localparam int ADDR_CTRL     = 0;
   localparam int ADDR_LEVEL    = 1;
   localparam int ADDR_NORM_NUM = 4;
   localparam int ADDR_NORM_PRI = 5;
   localparam int ADDR_FAST_NUM = 6;
   localparam int ADDR_FAST_PRI = 7;

   typedef enum logic [1:0] {
      CH_IDLE = 2'd0,
      CH_SORT = 2'd1,
      CH_HOLD = 2'd2
   } chan_state_e;

   // bit 8 route, bit 7 block, bits 6:0 priority
   typedef struct packed {
      logic                route;
      logic                blocked;
      logic [STAT_W-1:0]   prio;
   } src_cfg_t;

   localparam int CFG_W = $bits(src_cfg_t);

endpackage

// File: rtl/prio_irq_cfg.sv
module prio_irq_cfg
   import prio_irq_pkg::*;
#(
   parameter int NUM_SRC = 16,
   parameter int ADDR_W  = 8
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      we_i,
   input  logic [ADDR_W-1:0]         addr_i,
   input  logic [CFG_W-1:0]          wdata_i,
   output src_cfg_t [NUM_SRC-1:0]    cfg_o,
   output logic [7:0]                level_o,
   output logic                      cfg_wr_o
);

   localparam int OFS_W = ADDR_W - 1;

   logic             in_cfg_space;
   logic [OFS_W-1:0] ofs;

   assign in_cfg_space = addr_i[ADDR_W-1];
   assign ofs          = addr_i[OFS_W-1:0];
   assign cfg_wr_o     = we_i && in_cfg_space && (int'(ofs) < NUM_SRC);

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic hit;
      assign hit = we_i && in_cfg_space && (ofs == OFS_W'(i));
      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            cfg_o[i] <= '{route: 1'b0, blocked: 1'b1, prio: '0};
         end else if (hit) begin
            cfg_o[i] <= src_cfg_t'(wdata_i);
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         level_o <= 8'hFF;
      end else if (we_i && (addr_i == ADDR_W'(ADDR_LEVEL))) begin
         level_o <= wdata_i[7:0];
      end
   end

endmodule

// File: rtl/prio_irq_pick.sv
module prio_irq_pick
   import prio_irq_pkg::*;
#(
   parameter int NUM_SRC = 16,
   localparam int IDX_W  = $clog2(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0]        req_i,
   input  src_cfg_t [NUM_SRC-1:0]    cfg_i,
   output logic                      found_o,
   output logic [IDX_W-1:0]          idx_o,
   output logic [STAT_W-1:0]         prio_o
);

   logic              found_c;
   logic [IDX_W-1:0]  idx_c;
   logic [STAT_W-1:0] prio_c;

   // ascending scan: strict compare keeps the lower index on ties
   always_comb begin
      found_c = 1'b0;
      idx_c   = '0;
      prio_c  = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (req_i[i] && (!found_c || (cfg_i[i].prio < prio_c))) begin
            found_c = 1'b1;
            idx_c   = IDX_W'(i);
            prio_c  = cfg_i[i].prio;
         end
      end
   end

   assign found_o = found_c;
   assign idx_o   = idx_c;
   assign prio_o  = prio_c;

endmodule

// File: rtl/prio_irq_chan.sv
module prio_irq_chan
   import prio_irq_pkg::*;
#(
   parameter int NUM_SRC     = 16,
   parameter int SORT_CYCLES = 10,
   localparam int IDX_W      = $clog2(NUM_SRC),
   localparam int CNT_W      = $clog2(SORT_CYCLES)
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic [NUM_SRC-1:0]        src_i,
   input  logic [NUM_SRC-1:0]        cand_i,
   input  src_cfg_t [NUM_SRC-1:0]    cfg_i,
   input  logic                      cfg_wr_i,
   input  logic                      release_i,
   output logic                      req_o,
   output logic [STAT_W-1:0]         res_idx_o,
   output logic [STAT_W-1:0]         res_prio_o,
   output logic                      res_spur_o
);

   chan_state_e        st_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [NUM_SRC-1:0] snap_q;
   logic [IDX_W-1:0]   trig_q;
   logic [STAT_W-1:0]  tprio_q;
   logic               lost_q;
   logic               dirty_q;

   logic               s_found, l_found;
   logic [IDX_W-1:0]   s_idx, l_idx;
   logic [STAT_W-1:0]  s_prio, l_prio;

   logic               lost_now, dirty_now, last, moved;

   prio_irq_pick #(.NUM_SRC(NUM_SRC)) u_start_pick (
      .req_i   (cand_i),
      .cfg_i   (cfg_i),
      .found_o (s_found),
      .idx_o   (s_idx),
      .prio_o  (s_prio)
   );

   prio_irq_pick #(.NUM_SRC(NUM_SRC)) u_live_pick (
      .req_i   (cand_i & snap_q),
      .cfg_i   (cfg_i),
      .found_o (l_found),
      .idx_o   (l_idx),
      .prio_o  (l_prio)
   );

   assign lost_now  = lost_q | ~src_i[trig_q];
   assign dirty_now = dirty_q | cfg_wr_i;
   assign last      = (cnt_q == CNT_W'(SORT_CYCLES - 1));
   assign moved     = !l_found || (l_idx != trig_q) || (l_prio != tprio_q);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         st_q       <= CH_IDLE;
         cnt_q      <= '0;
         snap_q     <= '0;
         trig_q     <= '0;
         tprio_q    <= '0;
         lost_q     <= 1'b0;
         dirty_q    <= 1'b0;
         res_idx_o  <= '0;
         res_prio_o <= '0;
         res_spur_o <= 1'b0;
      end else begin
         unique case (st_q)
            CH_IDLE: begin
               if (s_found) begin
                  st_q    <= CH_SORT;
                  cnt_q   <= '0;
                  snap_q  <= cand_i;
                  trig_q  <= s_idx;
                  tprio_q <= s_prio;
                  lost_q  <= 1'b0;
                  dirty_q <= 1'b0;
               end
            end
            CH_SORT: begin
               lost_q  <= lost_now;
               dirty_q <= dirty_now;
               if (last) begin
                  st_q       <= CH_HOLD;
                  res_idx_o  <= STAT_W'(trig_q);
                  res_prio_o <= tprio_q;
                  res_spur_o <= lost_now | (dirty_now & moved);
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            CH_HOLD: begin
               if (release_i) st_q <= CH_IDLE;
            end
            default: st_q <= CH_IDLE;
         endcase
      end
   end

   assign req_o = (st_q == CH_HOLD);

endmodule

// File: rtl/prio_irq_sorter.sv
module prio_irq_sorter
   import prio_irq_pkg::*;
#(
   parameter int NUM_SRC     = 16,
   parameter int SORT_CYCLES = 10,
   parameter int ADDR_W      = 8
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               bus_we_i,
   input  logic [ADDR_W-1:0]  bus_addr_i,
   input  logic [31:0]        bus_wdata_i,
   output logic [31:0]        bus_rdata_o,
   output logic               norm_req_o,
   output logic               fast_req_o
);

   localparam int OFS_W  = ADDR_W - 1;
   localparam int FLAG_W = 32 - STAT_W;

   if (NUM_SRC < 2 || NUM_SRC > (1 << STAT_W)) begin : g_chk_src
      $error("NUM_SRC must lie between 2 and 128");
   end
   if (ADDR_W < 4 || NUM_SRC > (1 << OFS_W)) begin : g_chk_addr
      $error("ADDR_W too small for the register map");
   end
   if (SORT_CYCLES < 2) begin : g_chk_sort
      $error("SORT_CYCLES must be at least 2");
   end

   src_cfg_t [NUM_SRC-1:0]       cfg;
   logic [7:0]                   level;
   logic                         cfg_wr;
   logic                         level_on;
   logic [NUM_SRC-1:0]           pass;
   logic [NUM_CH-1:0][NUM_SRC-1:0] cand;
   logic [NUM_CH-1:0]            rel, req, spur;
   logic [NUM_CH-1:0][STAT_W-1:0] r_idx, r_prio;

   prio_irq_cfg #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_cfg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (bus_we_i),
      .addr_i   (bus_addr_i),
      .wdata_i  (bus_wdata_i[CFG_W-1:0]),
      .cfg_o    (cfg),
      .level_o  (level),
      .cfg_wr_o (cfg_wr)
   );

   assign level_on = ~level[7];

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_gate
      assign pass[i] = !level_on || (cfg[i].prio < level[STAT_W-1:0]);
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_cand
         assign cand[c][i] = src_i[i] && !cfg[i].blocked && pass[i]
                             && (cfg[i].route == c[0]);
      end

      assign rel[c] = bus_we_i && (bus_addr_i == ADDR_W'(ADDR_CTRL)) && bus_wdata_i[c];

      prio_irq_chan #(.NUM_SRC(NUM_SRC), .SORT_CYCLES(SORT_CYCLES)) u_chan (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .src_i      (src_i),
         .cand_i     (cand[c]),
         .cfg_i      (cfg),
         .cfg_wr_i   (cfg_wr),
         .release_i  (rel[c]),
         .req_o      (req[c]),
         .res_idx_o  (r_idx[c]),
         .res_prio_o (r_prio[c]),
         .res_spur_o (spur[c])
      );
   end

   assign norm_req_o = req[0];
   assign fast_req_o = req[1];

   always_comb begin
      bus_rdata_o = '0;
      if (bus_addr_i[ADDR_W-1]) begin
         for (int i = 0; i < NUM_SRC; i++) begin
            if (bus_addr_i[OFS_W-1:0] == OFS_W'(i)) begin
               bus_rdata_o = {{(32-CFG_W){1'b0}}, cfg[i]};
            end
         end
      end else begin
         case (bus_addr_i)
            ADDR_W'(ADDR_LEVEL):    bus_rdata_o = {24'h0, level};
            ADDR_W'(ADDR_NORM_NUM): bus_rdata_o = {{FLAG_W{spur[0]}}, r_idx[0]};
            ADDR_W'(ADDR_NORM_PRI): bus_rdata_o = {{FLAG_W{spur[0]}}, r_prio[0]};
            ADDR_W'(ADDR_FAST_NUM): bus_rdata_o = {{FLAG_W{spur[1]}}, r_idx[1]};
            ADDR_W'(ADDR_FAST_PRI): bus_rdata_o = {{FLAG_W{spur[1]}}, r_prio[1]};
            default:                bus_rdata_o = '0;
         endcase
      end
   end

endmodule

// File: rtl/prio_irq_sorter_chk.sv
module prio_irq_sorter_chk #(
   parameter int NUM_SRC     = 16,
   parameter int SORT_CYCLES = 10,
   parameter int ADDR_W      = 8
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              bus_we_i,
   input logic [ADDR_W-1:0] bus_addr_i,
   input logic [31:0]       bus_wdata_i,
   input logic [31:0]       bus_rdata_o,
   input logic              norm_req_o,
   input logic              fast_req_o
);

   logic norm_rel, fast_rel, stat_rd, num_rd;
   int   norm_low, fast_low;

   assign norm_rel = bus_we_i && (bus_addr_i == ADDR_W'(0)) && bus_wdata_i[0];
   assign fast_rel = bus_we_i && (bus_addr_i == ADDR_W'(0)) && bus_wdata_i[1];
   assign stat_rd  = (bus_addr_i >= ADDR_W'(4)) && (bus_addr_i <= ADDR_W'(7));
   assign num_rd   = (bus_addr_i == ADDR_W'(4)) || (bus_addr_i == ADDR_W'(6));

   // idle-time counters, saturating at the window length
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         norm_low <= 0;
         fast_low <= 0;
      end else begin
         norm_low <= norm_req_o ? 0 : ((norm_low < SORT_CYCLES) ? norm_low + 1 : norm_low);
         fast_low <= fast_req_o ? 0 : ((fast_low < SORT_CYCLES) ? fast_low + 1 : fast_low);
      end
   end

   AST_NORM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) (norm_req_o && !norm_rel) |=> norm_req_o) else $error("normal request dropped without release"); // R6
   AST_FAST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) (fast_req_o && !fast_rel) |=> fast_req_o) else $error("fast request dropped without release"); // R6
   AST_NORM_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni) (norm_req_o && norm_rel) |=> !norm_req_o) else $error("normal request survived release"); // R6
   AST_FAST_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni) (fast_req_o && fast_rel) |=> !fast_req_o) else $error("fast request survived release"); // R6
   AST_NORM_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(norm_req_o) |-> (norm_low >= SORT_CYCLES)) else $error("normal request rose before a full sort window"); // R3
   AST_FAST_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(fast_req_o) |-> (fast_low >= SORT_CYCLES)) else $error("fast request rose before a full sort window"); // R3
   AST_FLAG_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni) stat_rd |-> ((bus_rdata_o[31:7] == '0) || (bus_rdata_o[31:7] == '1))) else $error("flag field not uniform"); // R10
   AST_NUM_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni) num_rd |-> (int'(bus_rdata_o[6:0]) < NUM_SRC)) else $error("winner number out of range"); // R4

endmodule

bind prio_irq_sorter prio_irq_sorter_chk #(
   .NUM_SRC(NUM_SRC), .SORT_CYCLES(SORT_CYCLES), .ADDR_W(ADDR_W)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .bus_we_i    (bus_we_i),
   .bus_addr_i  (bus_addr_i),
   .bus_wdata_i (bus_wdata_i),
   .bus_rdata_o (bus_rdata_o),
   .norm_req_o  (norm_req_o),
   .fast_req_o  (fast_req_o)
);

// File: tb/prio_irq_sorter_bench.sv
module prio_irq_sorter_bench;

   localparam int NS   = 16;
   localparam int SORT = 10;
   localparam int AW   = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src = '0;
   logic          we = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic          norm_req, fast_req;

   int total = 0;
   int fails = 0;
   int cyc   = 0;

   always #5 clk = ~clk;

   prio_irq_sorter #(.NUM_SRC(NS), .SORT_CYCLES(SORT), .ADDR_W(AW)) u_prio_irq_sorter (
      .clk_i(clk), .rst_ni(rst_n), .src_i(src), .bus_we_i(we), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata), .norm_req_o(norm_req), .fast_req_o(fast_req)
   );

   // ---------------- behavioural reference model ----------------
   int            m_prio [NS];
   bit            m_blk  [NS];
   bit            m_fast [NS];
   int            m_level;
   int            m_st   [2];
   int            m_cnt  [2];
   bit [NS-1:0]   m_snap [2];
   int            m_trig [2];
   int            m_tp   [2];
   bit            m_lost [2];
   bit            m_dirty[2];

   function automatic bit [NS-1:0] eligible(int ch);
      bit [NS-1:0] v = '0;
      for (int i = 0; i < NS; i++)
         v[i] = src[i] && !m_blk[i] && (int'(m_fast[i]) == ch)
                && (m_level >= 128 || m_prio[i] < m_level);
      return v;
   endfunction

   function automatic int best(bit [NS-1:0] set);
      int b = -1;
      for (int i = 0; i < NS; i++)
         if (set[i] && (b < 0 || m_prio[i] < m_prio[b])) b = i;
      return b;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NS; i++) begin m_prio[i] = 0; m_blk[i] = 1; m_fast[i] = 0; end
         m_level = 255;
         for (int c = 0; c < 2; c++) m_st[c] = 0;
      end else begin
         bit cfgwr;
         cfgwr = we && addr[7] && (int'(addr[6:0]) < NS);
         for (int c = 0; c < 2; c++) begin
            bit [NS-1:0] el;
            int b;
            el = eligible(c);
            if (m_st[c] == 0) begin
               b = best(el);
               if (b >= 0) begin
                  m_st[c] = 1; m_cnt[c] = 0; m_snap[c] = el; m_trig[c] = b;
                  m_tp[c] = m_prio[b]; m_lost[c] = 0; m_dirty[c] = 0;
               end
            end else if (m_st[c] == 1) begin
               m_lost[c]  = m_lost[c] | !src[m_trig[c]];
               m_dirty[c] = m_dirty[c] | cfgwr;
               m_cnt[c]++;
               if (m_cnt[c] == SORT) m_st[c] = 2;
            end else begin
               if (we && addr == 0 && wdata[c]) m_st[c] = 0;
            end
         end
         if (cfgwr) begin
            m_prio[addr[3:0]] = int'(wdata[6:0]);
            m_blk [addr[3:0]] = wdata[7];
            m_fast[addr[3:0]] = wdata[8];
         end
         if (we && addr == 1) m_level = int'(wdata[7:0]);
      end
   end

   // every-cycle comparison of the request lines against the model (R3 R6)
   always @(negedge clk) begin
      if (rst_n) begin
         total++;
         if ({fast_req, norm_req} !== {m_st[1] == 2, m_st[0] == 2}) begin
            fails++;
            $display("FAIL R3/R6 cycle compare act=%b expected=%b", {fast_req, norm_req},
                     {m_st[1] == 2, m_st[0] == 2});
         end
      end
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         fails++; total++;
         $display("FAIL watchdog expired act=%0d expected<=50000", cyc);
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [AW-1:0] a, logic [31:0] d);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0; wdata = '0;
   endtask

   task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cleanup();
      src = '0;
      wr(0, 3);
      step(14);
      wr(0, 3);
      step(2);
   endtask

   initial begin
      logic [31:0] v;
      step(3);
      rst_n = 1'b1;
      step(1);

      // R1 reset state
      chk("R1 normal line low", {31'h0, norm_req}, 0);
      chk("R1 fast line low", {31'h0, fast_req}, 0);
      rd(1, v);    chk("R1 level reset", v, 32'hFF);
      rd(4, v);    chk("R1 normal number reset", v, 0);
      rd(7, v);    chk("R1 fast priority reset", v, 0);
      rd(8'h80, v); chk("R1 source config reset", v, 32'h80);

      // R2 config layout and readback
      wr(8'h83, 32'h125);
      rd(8'h83, v); chk("R2 config readback", v, 32'h125);
      wr(8'h83, 32'hFFFF_FFFF);
      rd(8'h83, v); chk("R2 config upper bits dropped", v, 32'h1FF);
      wr(8'h83, 32'h80);
      wr(8'h90, 32'h005);
      rd(8'h90, v); chk("R2 unimplemented source reads 0", v, 0);

      // R3 window length, R4 result words
      wr(8'h82, 5);
      src[2] = 1'b1;
      step(10);
      chk("R3 still low after 9 edges", {31'h0, norm_req}, 0);
      step(1);
      chk("R3 high after 10 edges", {31'h0, norm_req}, 1);
      rd(4, v); chk("R4 normal number", v, 2);
      rd(5, v); chk("R4 normal priority", v, 5);
      chk("R5 fast line untouched", {31'h0, fast_req}, 0);

      // R6 release, R7 automatic restart
      wr(0, 2);
      chk("R6 fast release leaves normal high", {31'h0, norm_req}, 1);
      wr(0, 1);
      chk("R6 normal release drops line", {31'h0, norm_req}, 0);
      step(10);
      chk("R7 restart still sorting", {31'h0, norm_req}, 0);
      step(1);
      chk("R7 restart delivers pending source", {31'h0, norm_req}, 1);
      cleanup();
      chk("R6 line low after cleanup", {31'h0, norm_req}, 0);

      // R4 lowest value wins, tie to lower index
      wr(8'h84, 9); wr(8'h86, 3); wr(8'h87, 3);
      src = 16'h00D0;
      step(12);
      rd(4, v); chk("R4 tie resolved to lower index", v, 6);
      rd(5, v); chk("R4 tie priority", v, 3);
      cleanup();

      // R5 routing and blocking
      wr(8'h89, 32'h101); wr(8'h8A, 32'h080); wr(8'h8B, 7);
      src = 16'h0E00;
      step(12);
      chk("R5 fast line raised", {31'h0, fast_req}, 1);
      rd(6, v); chk("R5 fast number", v, 9);
      rd(7, v); chk("R5 fast priority", v, 1);
      rd(4, v); chk("R5 blocked source skipped", v, 11);
      rd(5, v); chk("R5 normal priority", v, 7);
      cleanup();

      // R7 late source excluded from running sort
      src[2] = 1'b1;
      step(4);
      src[6] = 1'b1;
      step(12);
      rd(4, v); chk("R7 running sort keeps first winner", v, 2);
      wr(0, 1);
      step(12);
      rd(4, v); chk("R7 next sort picks late source", v, 6);
      cleanup();

      // R8 level gating on both lines, R9 delivery after raising it
      wr(1, 5);
      src[4] = 1'b1; src[9] = 1'b1;
      step(30);
      chk("R8 gated normal source held back", {31'h0, norm_req}, 0);
      chk("R8 fast source below level passes", {31'h0, fast_req}, 1);
      rd(6, v); chk("R8 fast winner", v, 9);
      wr(1, 10);
      step(12);
      chk("R9 gated source delivered", {31'h0, norm_req}, 1);
      rd(4, v); chk("R9 delivered number", v, 4);
      wr(1, 32'hFF);
      rd(1, v); chk("R8 level readback", v, 32'hFF);
      cleanup();

      // R10 trigger drops mid-window
      src[2] = 1'b1;
      step(4);
      src[2] = 1'b0;
      step(12);
      chk("R10 line raised for flagged result", {31'h0, norm_req}, 1);
      rd(4, v); chk("R10 flag in number word", v, 32'hFFFF_FF82);
      rd(5, v); chk("R10 flag in priority word", v, 32'hFFFF_FF85);
      cleanup();

      // R11 config write that changes the winner
      wr(8'h81, 5); wr(8'h83, 8);
      src = 16'h000A;
      step(3);
      wr(8'h81, 12);
      step(12);
      rd(4, v); chk("R11 changed winner flagged", v, 32'hFFFF_FF81);
      rd(5, v); chk("R11 changed winner priority flagged", v, 32'hFFFF_FF85);
      cleanup();

      // R11 config write that leaves the winner alone
      src = 16'h000A;
      step(3);
      wr(8'h8C, 2);
      step(12);
      rd(4, v); chk("R11 harmless write not flagged", v, 3);
      rd(5, v); chk("R11 harmless write priority", v, 8);
      cleanup();

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule